// File: doc/BRIEF.md
# UART Modem Control and Status Lines

This block sits beside a UART's shift registers and owns its modem handshake lines. A control register drives four active-low handshake outputs. Four active-low handshake inputs are synchronised and shown inverted in a status register. The status register also has four change flags, which a read of that register clears. While the enable input is high, any set change flag raises a modem-status interrupt request. This request is the lowest-priority source (level 4) of the UART's interrupt logic.

A diagnostic loopback bit reroutes the serial path. While it is set, the transmit shift output feeds the receive shift input and the serial output pin idles at mark (1). The four handshake outputs go inactive (high), and the low four control bits take the place of the external status inputs. Software can then exercise both data paths and the modem interrupt with no cable attached. The block carries no streamed data: the serial bits pass through combinationally, and every other pin is a plain level or a one-cycle strobe.

Top module: `uart_modem_ctl`

## Requirements
- R1: The control register holds DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3 and LOOP in bit 4. A write takes effect at the next clock edge. Bits 7 to 5 always read 0, whatever is written to them.
- R2: Outside loopback, each handshake output is the inverse of its control bit: dtr_n = !bit0, rts_n = !bit1, out1_n = !bit2, out2_n = !bit3.
- R3: With LOOP set, sout is 1, rx_shift_in equals tx_shift_out, and sin has no effect. With LOOP clear, sout equals tx_shift_out and rx_shift_in equals sin.
- R4: With LOOP set, all four handshake outputs are 1 and the external status pins have no effect. The status level bits are then CTS=RTS bit, DSR=DTR bit, RI=OUT1 bit and DCD=OUT2 bit.
- R5: Outside loopback, status bits 4 to 7 are the inverted levels of cts_n, dsr_n, ri_n and dcd_n, in that order. A pin change becomes visible after the second rising clock edge.
- R6: Status bits 0, 1 and 3 (CTS, DSR and DCD change flags) set when their status level changes in either direction. A pin change sets its flag after the third rising clock edge.
- R7: Status bit 2 sets only when ri_n goes from 0 to 1, which is a fall of the RI status level. A change of ri_n from 1 to 0 leaves it clear.
- R8: A clock edge with stat_rd high clears all four change flags. If a new change lands on that same edge, its flag stays set.
- R9: irq is 1 exactly when msi_en is 1 and at least one change flag is set.
- R10: After reset, the control register and all change flags are 0, all four handshake outputs are 1, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read data |
| stat_rd | input | 1 | Status register read strobe (clears change flags) |
| stat_rdata | output | 8 | Status register read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |
| tx_shift_out | input | 1 | Bit from the transmit shift register |
| rx_shift_in | output | 1 | Bit to the receive shift register |
| sin | input | 1 | Serial input pin |
| sout | output | 1 | Serial output pin |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |

## Verification
A wrong synchroniser stage or a wrong previous-level register shows up as a status or flag bit that moves one cycle early or late. It can also show as a spurious or missing flag after a pin toggle. Both appear in stat_rdata within three edges of the toggle. A stuck or lost change flag stays visible on stat_rdata and irq until the next read. A wrong loopback mux shows at once on sout, rx_shift_in or the handshake pins.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  // status line index (status level bit = 4 + index)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctrl_t;

  localparam int CTRL_W = $bits(mdm_ctrl_t);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= {WIDTH{RST_VAL}};
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
          else        stg[s] <= stg[s-1];
      end
    end
    if (STAGES >= 2) begin : g_chk
      assert_sync_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stg[STAGES-1] == $past(stg[STAGES-2]));
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output mdm_ctrl_t         ctrl
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  ctrl <= '0;
    else if (wr) ctrl <= mdm_ctrl_t'(wdata);

  assert_wr_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctrl == mdm_ctrl_t'($past(wdata)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl));
endmodule

// File: rtl/mdm_line_mux.sv
module mdm_line_mux
  import mdm_pkg::*;
(
  input  mdm_ctrl_t         ctrl,
  input  logic [NLINES-1:0] pin_lvl_n,
  input  logic              tx_bit,
  input  logic              sin,
  output logic              sout,
  output logic              rx_bit,
  output logic [NLINES-1:0] ctl_pins_n,
  output logic [NLINES-1:0] line_lvl
);
  logic [NLINES-1:0] fb_lvl;

  always_comb begin
    fb_lvl          = '0;
    fb_lvl[LN_CTS]  = ctrl.rts;
    fb_lvl[LN_DSR]  = ctrl.dtr;
    fb_lvl[LN_RI]   = ctrl.out1;
    fb_lvl[LN_DCD]  = ctrl.out2;
  end

  // ctl_pins_n order: {out2_n, out1_n, rts_n, dtr_n}
  assign ctl_pins_n = ctrl.loop ? {NLINES{1'b1}}
                                : ~{ctrl.out2, ctrl.out1, ctrl.rts, ctrl.dtr};
  assign line_lvl   = ctrl.loop ? fb_lvl : ~pin_lvl_n;
  assign sout       = ctrl.loop ? 1'b1 : tx_bit;
  assign rx_bit     = ctrl.loop ? tx_bit : sin;
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl,
  input  logic              rd,
  output logic [NLINES-1:0] delta
);
  logic [NLINES-1:0] prev;
  logic [NLINES-1:0] evt;

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_evt
      if (i == LN_RI) begin : g_trail
        assign evt[i] = prev[i] & ~lvl[i];
      end else begin : g_any
        assign evt[i] = prev[i] ^ lvl[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev  <= '0;
      delta <= '0;
    end else begin
      prev  <= lvl;
      delta <= evt | (delta & ~{NLINES{rd}});
    end

  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && lvl == prev) |=> delta == '0);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (delta & $past(delta)) == $past(delta));
  assert_teri_rise_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta[LN_RI] && !(prev[LN_RI] && !lvl[LN_RI])) |=> !delta[LN_RI]);
  assert_change_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[LN_CTS] != prev[LN_CTS]) |=> delta[LN_CTS]);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  input  logic       stat_rd,
  output logic [7:0] stat_rdata,
  input  logic       msi_en,
  output logic       irq,
  input  logic       tx_shift_out,
  output logic       rx_shift_in,
  input  logic       sin,
  output logic       sout,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n
);
  mdm_ctrl_t         ctrl;
  logic [NLINES-1:0] pin_sync_n;
  logic [NLINES-1:0] line_lvl;
  logic [NLINES-1:0] delta;
  logic [NLINES-1:0] ctl_pins_n;

  mdm_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .wdata (ctrl_wdata[CTRL_W-1:0]),
    .ctrl  (ctrl)
  );

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dcd_n, ri_n, dsr_n, cts_n}),
    .q     (pin_sync_n)
  );

  mdm_line_mux u_mux (
    .ctrl       (ctrl),
    .pin_lvl_n  (pin_sync_n),
    .tx_bit     (tx_shift_out),
    .sin        (sin),
    .sout       (sout),
    .rx_bit     (rx_shift_in),
    .ctl_pins_n (ctl_pins_n),
    .line_lvl   (line_lvl)
  );

  mdm_delta u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (line_lvl),
    .rd    (stat_rd),
    .delta (delta)
  );

  assign {out2_n, out1_n, rts_n, dtr_n} = ctl_pins_n;
  assign ctrl_rdata = {{(8-CTRL_W){1'b0}}, ctrl};
  assign stat_rdata = {line_lvl, delta};
  assign irq        = msi_en & (|delta);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[7:5] != 3'b0) |=> ctrl_rdata[7:5] == 3'b0);
  assert_loop_feedback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[4] |-> (stat_rdata[7:4] ==
      {ctrl_rdata[3], ctrl_rdata[2], ctrl_rdata[0], ctrl_rdata[1]}));
  assert_loop_pins_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[4] |-> ({dtr_n, rts_n, out1_n, out2_n, sout} == 5'b11111));
  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msi_en && stat_rdata[3:0] != 4'b0));
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, stat_rd = 1'b0, msi_en = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic tx_shift_out = 1'b1, sin = 1'b1;
  logic [3:0] pins_n = 4'hF; // {dcd_n, ri_n, dsr_n, cts_n}
  logic [7:0] ctrl_rdata, stat_rdata;
  logic irq, rx_shift_in, sout, dtr_n, rts_n, out1_n, out2_n;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_s1, m_s2, m_prev, m_delta;
  logic [4:0] m_ctrl;

  always #5 clk = ~clk;

  uart_modem_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .msi_en(msi_en), .irq(irq), .tx_shift_out(tx_shift_out),
    .rx_shift_in(rx_shift_in), .sin(sin), .sout(sout),
    .cts_n(pins_n[0]), .dsr_n(pins_n[1]), .ri_n(pins_n[2]), .dcd_n(pins_n[3]),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  function automatic logic [3:0] exp_lvl();
    if (m_ctrl[4]) return {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1]};
    return ~m_s2;
  endfunction

  function automatic logic [3:0] exp_pins(); // {dtr_n, rts_n, out1_n, out2_n}
    if (m_ctrl[4]) return 4'hF;
    return ~{m_ctrl[0], m_ctrl[1], m_ctrl[2], m_ctrl[3]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 ctrl readback", ctrl_rdata, {3'b0, m_ctrl});
    chk("R2/R4 handshake pins", {4'b0, dtr_n, rts_n, out1_n, out2_n}, {4'b0, exp_pins()});
    chk("R3 sout", {7'b0, sout}, {7'b0, m_ctrl[4] ? 1'b1 : tx_shift_out});
    chk("R3 rx_shift_in", {7'b0, rx_shift_in}, {7'b0, m_ctrl[4] ? tx_shift_out : sin});
    chk("R5/R4 status levels", {4'b0, stat_rdata[7:4]}, {4'b0, exp_lvl()});
    chk("R6/R7/R8 change flags", {4'b0, stat_rdata[3:0]}, {4'b0, m_delta});
    chk("R9 irq", {7'b0, irq}, {7'b0, msi_en & (|m_delta)});
  endtask

  // one clock edge, model updated from the values driven before it
  task automatic tick();
    logic [3:0] lv, ev;
    @(posedge clk);
    lv = exp_lvl();
    ev = m_prev ^ lv;
    ev[2] = m_prev[2] & ~lv[2];
    m_delta = ev | (m_delta & ~{4{stat_rd}});
    m_prev = lv;
    m_s2 = m_s1;
    m_s1 = pins_n;
    if (ctrl_wr) m_ctrl = ctrl_wdata[4:0];
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    ctrl_wr = 0; stat_rd = 0;
  endtask

  initial begin
    m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 0; m_delta = 0; m_ctrl = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 ctrl after reset", ctrl_rdata, 8'h00);
    chk("R10 pins after reset", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    chk("R10 flags after reset", stat_rdata, 8'h00);
    chk("R10 irq after reset", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1; #1;
    check_all();

    // R1: reserved bits read 0, write of 0xEB
    ctrl_wr = 1; ctrl_wdata = 8'hEB; tick(); idle(); #1;
    chk("R1 reserved bits zero", ctrl_rdata, 8'h0B);
    chk("R2 dtr/rts/out1/out2 from 0x0B", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h02);
    check_all();
    ctrl_wr = 1; ctrl_wdata = 8'h00; tick(); idle(); check_all();

    // R7: ri_n 1->0 must not set flag 2; 0->1 must
    msi_en = 1;
    pins_n[2] = 0; repeat (3) tick(); check_all();
    chk("R7 ri_n falling leaves flag", {7'b0, stat_rdata[2]}, 8'h00);
    pins_n[2] = 1; repeat (3) tick(); check_all();
    chk("R7 ri_n rising sets flag", {7'b0, stat_rdata[2]}, 8'h01);
    chk("R9 irq with flag", {7'b0, irq}, 8'h01);
    stat_rd = 1; tick(); idle(); check_all();
    chk("R8 read clears", {4'b0, stat_rdata[3:0]}, 8'h00);

    // R5/R6 timing: cts_n change, level after 2 edges, flag after 3
    pins_n[0] = 0; tick();
    chk("R5 not yet visible", {7'b0, stat_rdata[4]}, 8'h00);
    tick();
    chk("R5 level after two edges", {7'b0, stat_rdata[4]}, 8'h01);
    chk("R6 flag not yet", {7'b0, stat_rdata[0]}, 8'h00);
    stat_rd = 1; tick(); idle(); check_all();
    chk("R8 event on read edge kept", {7'b0, stat_rdata[0]}, 8'h01);
    stat_rd = 1; tick(); idle(); check_all();

    // R3/R4 loopback: pins ignored, feedback mapping
    ctrl_wr = 1; ctrl_wdata = 8'h11; tick(); idle(); check_all();
    chk("R4 loop DSR from DTR", stat_rdata[7:4], 8'h02);
    pins_n = 4'h0; sin = 0; tx_shift_out = 1; repeat (3) tick(); check_all();
    chk("R3 loop sout mark", {7'b0, sout}, 8'h01);
    chk("R4 loop pins idle", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    tx_shift_out = 0; #1;
    chk("R3 loop rx follows tx", {7'b0, rx_shift_in}, 8'h00);
    ctrl_wr = 1; ctrl_wdata = 8'h10; tick(); idle(); check_all();
    pins_n = 4'hF; ctrl_wr = 1; ctrl_wdata = 8'h00; tick(); idle();
    stat_rd = 1; repeat (3) tick(); idle(); check_all();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) pins_n[$urandom_range(3)] ^= 1'b1;
      stat_rd = ($urandom_range(3) == 0);
      ctrl_wr = ($urandom_range(15) == 0);
      ctrl_wdata = 8'($urandom);
      if ($urandom_range(3) == 0) ctrl_wdata[4] = 1'b0;
      msi_en = ($urandom_range(7) != 0);
      tx_shift_out = 1'($urandom);
      sin = 1'($urandom);
      #1;
      check_all();
      tick();
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule